// File: doc/BRIEF.md
# Branch Instruction Sequencer

This block fetches and executes the jump subset of an 8-bit accumulator CPU instruction set, one T-state per clock. It reads bytes through a byte-wide memory port and keeps a 16-bit program counter. It reads three 16-bit pointer registers (HL, IX and IY) and a 4-bit flag vector from its surroundings but never writes them. For each instruction it runs the opcode fetch, the operand reads and any internal delay cycle with the exact machine-cycle and T-state counts. It then loads a new program counter or falls through to the next instruction.

An opcode that is not one of the supported jumps is consumed and flagged as illegal, and the unit moves on to the next byte. At the end of every instruction the block gives a one-clock done strobe with the T-state and machine-cycle totals. That same clock is the first T-state of the next opcode fetch, so instructions run back to back with no idle clocks.

Top module: `branch_seq`

## Requirements
- R1: A synchronous active-low reset sets the program counter to 0x0000, clears the done and illegal strobes and starts an opcode fetch at address 0x0000, also when it arrives in the middle of an instruction.
- R2: Bus timing. An opcode fetch lasts 4 clocks with `m1_cycle` and `mem_rd` high. An operand read lasts 3 clocks with `mem_rd` high and `m1_cycle` low. `mem_addr` equals the program counter, the byte is taken in the last clock of its cycle, and the program counter steps by one after each byte.
- R3: Opcode 0xC3 with a low target byte and then a high target byte loads the target into the program counter, using 3 machine cycles and 10 T-states.
- R4: Opcode pattern 11ccc010 reads both target bytes in 10 T-states and 3 machine cycles, whatever the outcome. It loads the target only if condition ccc holds, otherwise it continues at the byte after the instruction. Condition codes 0 to 7 are: Z clear, Z set, C clear, C set, PV clear, PV set, S clear, S set. The flag input bits are S=bit 3, Z=bit 2, PV=bit 1, C=bit 0.
- R5: Opcode 0xE9 loads `hl_val` into the program counter in 1 machine cycle and 4 T-states.
- R6: Prefix 0xDD then 0xE9 loads `ix_val`, and prefix 0xFD then 0xE9 loads `iy_val`. Both use 2 opcode fetches, 2 machine cycles and 8 T-states.
- R7: Opcode 0x18 then a displacement byte d jumps to (address of the opcode + 2 + sign-extended d) modulo 2^16, using 3 machine cycles and 12 T-states. The third cycle is 5 clocks with `mem_rd` low.
- R8: Opcode pattern 001kk000 (0x20, 0x28, 0x30, 0x38) then d uses condition kk with codes 0 to 3 as in R4. If taken it behaves as R7. If not taken it continues at opcode address + 2 after 2 machine cycles and 7 T-states, with no internal cycle.
- R9: Any other first byte raises `illegal_op` with the done strobe, after 1 machine cycle and 4 T-states, and the program counter advances by 1. A 0xDD or 0xFD prefix followed by a byte other than 0xE9 raises `illegal_op` after 2 machine cycles and 8 T-states, and the program counter advances by 2.
- R10: `instr_done` is high for exactly one clock, in the first clock of the next opcode fetch. During that clock `instr_tstates` and `instr_mcycles` hold the totals of the instruction just finished and `pc_q` holds the new program counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one T-state per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| flags_in | input | 4 | Flag vector {S, Z, PV, C} |
| hl_val | input | 16 | HL pointer register value |
| ix_val | input | 16 | IX index register value |
| iy_val | input | 16 | IY index register value |
| mem_rdata | input | 8 | Byte read from memory at `mem_addr` |
| mem_addr | output | 16 | Memory read address |
| mem_rd | output | 1 | Read strobe, high during fetch and operand cycles |
| m1_cycle | output | 1 | High during opcode fetch cycles |
| pc_q | output | 16 | Program counter |
| instr_done | output | 1 | One-clock end-of-instruction strobe |
| instr_tstates | output | 5 | T-states used by the finished instruction |
| instr_mcycles | output | 2 | Machine cycles used by the finished instruction |
| illegal_op | output | 1 | Finished instruction was not a supported jump |

## Verification
A wrong cycle state or a step counter that is off by one shows up within one instruction. The bench then sees the wrong number of clocks with `mem_rd` or `m1_cycle` high, or `instr_done` arriving a clock early or late with wrong totals. A corrupted latched opcode, operand byte or condition decision does not show until the done clock. There the new `pc_q`, and the address of the next fetch, differ from the target the bench computes. Every instruction is therefore checked for its clock count, strobe profile, totals, illegal flag and next address.

// File: rtl/branch_pkg.sv
// branch_pkg
// Shared types and constants for the branch sequencer: the bus cycle kinds,
// the decoded instruction class and the flag bit positions of flags_in.
// Assumes the 4-bit flag vector layout {S, Z, PV, C}.
package branch_pkg;

    typedef enum logic [2:0] {
        CY_FETCH    = 3'd0,
        CY_PFETCH   = 3'd1,
        CY_RD_LO    = 3'd2,
        CY_RD_HI    = 3'd3,
        CY_RD_DISP  = 3'd4,
        CY_INTERNAL = 3'd5
    } cycle_e;

    typedef enum logic [2:0] {
        OP_JP_ABS = 3'd0,
        OP_JP_CC  = 3'd1,
        OP_JP_PTR = 3'd2,
        OP_PREFIX = 3'd3,
        OP_JR     = 3'd4,
        OP_JR_CC  = 3'd5,
        OP_BAD    = 3'd6
    } op_e;

    typedef struct packed {
        op_e        kind;
        logic [2:0] cond;
        logic       use_iy;
    } dec_t;

    localparam int FLAG_S  = 3;
    localparam int FLAG_Z  = 2;
    localparam int FLAG_PV = 1;
    localparam int FLAG_C  = 0;

    localparam logic [7:0] OPC_JP_ABS = 8'hC3;
    localparam logic [7:0] OPC_JP_PTR = 8'hE9;
    localparam logic [7:0] OPC_JR     = 8'h18;

endpackage

// File: rtl/branch_decode.sv
// branch_decode
// Purely combinational classifier for a fetched opcode byte. It returns the
// instruction class, the condition field (3-bit for absolute, 2-bit zero
// extended for relative) and the index select bit of a prefix byte.
// Assumes it is sampled only when the byte is an opcode-fetch result.
module branch_decode
    import branch_pkg::*;
(
    input  logic [7:0] opcode,
    output dec_t       dec
);

    // Match the byte against each supported jump pattern in priority order.
    always_comb begin
        dec = '{kind: OP_BAD, cond: 3'd0, use_iy: 1'b0};
        if (opcode == OPC_JP_ABS) begin
            dec.kind = OP_JP_ABS;
        end else if (opcode[7:6] == 2'b11 && opcode[2:0] == 3'b010) begin
            dec.kind = OP_JP_CC;
            dec.cond = opcode[5:3];
        end else if (opcode == OPC_JP_PTR) begin
            dec.kind = OP_JP_PTR;
        end else if ({opcode[7:6], opcode[4:0]} == 7'b11_11101) begin
            dec.kind   = OP_PREFIX;
            dec.use_iy = opcode[5];
        end else if (opcode == OPC_JR) begin
            dec.kind = OP_JR;
        end else if (opcode[7:5] == 3'b001 && opcode[2:0] == 3'b000) begin
            dec.kind = OP_JR_CC;
            dec.cond = {1'b0, opcode[4:3]};
        end
    end

endmodule

// File: rtl/branch_cond.sv
// branch_cond
// Evaluates a 3-bit condition code against the flag vector. Even codes test
// a flag clear, odd codes test it set; pairs in order Z, C, PV, S.
// Assumes flags_in is stable in the clock where the decision is taken.
module branch_cond
    import branch_pkg::*;
#(
    parameter int NCOND = 8,
    localparam int CW   = $clog2(NCOND)
) (
    input  logic [3:0]    flags_in,
    input  logic [CW-1:0] code,
    output logic          met
);

    logic [3:0]       flag_pair;
    logic [NCOND-1:0] met_vec;

    assign flag_pair = {flags_in[FLAG_S], flags_in[FLAG_PV], flags_in[FLAG_C], flags_in[FLAG_Z]};

    // One comparator per condition code: flag of pair i/2 equal to bit i%2.
    for (genvar i = 0; i < NCOND; i++) begin : g_cond
        assign met_vec[i] = (flag_pair[i / 2] == 1'(i % 2));
    end

    assign met = met_vec[code];

endmodule

// File: rtl/branch_target.sv
// branch_target
// Relative target adder: base address plus a sign-extended displacement,
// wrapping modulo 2^AW. Base is the address after the two-byte instruction.
module branch_target #(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic [AW-1:0] base,
    input  logic [DW-1:0] disp,
    output logic [AW-1:0] target
);

    assign target = base + {{(AW - DW){disp[DW-1]}}, disp};

endmodule

// File: rtl/branch_timer.sv
// branch_timer
// Counts T-states inside the current bus cycle and flags its last clock,
// and keeps running T-state and machine-cycle totals for the instruction.
// Assumes cyc_len is at least 1 and constant for the length of a cycle.
module branch_timer #(
    parameter int STEP_W = 3,
    parameter int TOT_W  = 5,
    parameter int M_W    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STEP_W-1:0] cyc_len,
    input  logic              instr_end,
    output logic              last_t,
    output logic [TOT_W-1:0]  tot_t,
    output logic [M_W-1:0]    tot_m
);

    logic [STEP_W-1:0] step_q;

    assign last_t = (step_q == cyc_len - STEP_W'(1));

    // Step through the T-states of one bus cycle, wrapping at its end.
    always_ff @(posedge clk) begin
        if (!rst_n || last_t) begin
            step_q <= '0;
        end else begin
            step_q <= step_q + STEP_W'(1);
        end
    end

    // Accumulate instruction totals, cleared when an instruction ends.
    always_ff @(posedge clk) begin
        if (!rst_n || instr_end) begin
            tot_t <= '0;
            tot_m <= '0;
        end else begin
            tot_t <= tot_t + TOT_W'(1);
            if (last_t) begin
                tot_m <= tot_m + M_W'(1);
            end
        end
    end

endmodule

// File: rtl/branch_seq.sv
// branch_seq
// Cycle-exact fetch/execute sequencer for the jump instructions. Each clock
// is one T-state. Opcode fetches last FETCH_T clocks, operand reads READ_T,
// the internal cycle of a taken relative jump INT_T with no bus read.
// The byte on mem_rdata is taken in the last clock of a read cycle.
// A done strobe coincides with the first clock of the next opcode fetch.
// Assumes memory returns data combinationally for the address driven.
module branch_seq
    import branch_pkg::*;
#(
    parameter int FETCH_T  = 4,
    parameter int READ_T   = 3,
    parameter int INT_T    = 5,
    localparam int MAX_LEN = (FETCH_T > READ_T) ? ((FETCH_T > INT_T) ? FETCH_T : INT_T)
                                                : ((READ_T > INT_T) ? READ_T : INT_T),
    localparam int STEP_W  = $clog2(MAX_LEN + 1),
    localparam int TOT_W   = $clog2(2 * FETCH_T + 2 * READ_T + INT_T + 1),
    localparam int M_W     = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       flags_in,
    input  logic [15:0]      hl_val,
    input  logic [15:0]      ix_val,
    input  logic [15:0]      iy_val,
    input  logic [7:0]       mem_rdata,
    output logic [15:0]      mem_addr,
    output logic             mem_rd,
    output logic             m1_cycle,
    output logic [15:0]      pc_q,
    output logic             instr_done,
    output logic [TOT_W-1:0] instr_tstates,
    output logic [M_W-1:0]   instr_mcycles,
    output logic             illegal_op
);

    cycle_e            cyc_q, cyc_d;
    dec_t              dec_q, dec_d, dec_now;
    logic [15:0]       pc_d, pc_incr, rel_target;
    logic [7:0]        lo_q, lo_d, disp_q, disp_d;
    logic [STEP_W-1:0] cyc_len;
    logic              last_t, end_instr, bad_op, cond_met;
    logic [TOT_W-1:0]  tot_t;
    logic [M_W-1:0]    tot_m;

    branch_decode u_decode (
        .opcode (mem_rdata),
        .dec    (dec_now)
    );

    branch_cond #(.NCOND(8)) u_cond (
        .flags_in (flags_in),
        .code     (dec_q.cond),
        .met      (cond_met)
    );

    branch_target #(.AW(16), .DW(8)) u_target (
        .base   (pc_q),
        .disp   (disp_q),
        .target (rel_target)
    );

    branch_timer #(.STEP_W(STEP_W), .TOT_W(TOT_W), .M_W(M_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .cyc_len   (cyc_len),
        .instr_end (end_instr),
        .last_t    (last_t),
        .tot_t     (tot_t),
        .tot_m     (tot_m)
    );

    assign pc_incr  = pc_q + 16'd1;
    assign mem_addr = pc_q;
    assign mem_rd   = (cyc_q != CY_INTERNAL);
    assign m1_cycle = (cyc_q == CY_FETCH) || (cyc_q == CY_PFETCH);

    // Pick the length of the bus cycle currently running.
    always_comb begin
        unique case (cyc_q)
            CY_FETCH, CY_PFETCH: cyc_len = STEP_W'(FETCH_T);
            CY_INTERNAL:         cyc_len = STEP_W'(INT_T);
            default:             cyc_len = STEP_W'(READ_T);
        endcase
    end

    // Decide the next cycle, program counter and latched bytes at cycle end.
    always_comb begin
        cyc_d     = cyc_q;
        pc_d      = pc_q;
        dec_d     = dec_q;
        lo_d      = lo_q;
        disp_d    = disp_q;
        end_instr = 1'b0;
        bad_op    = 1'b0;
        if (last_t) begin
            unique case (cyc_q)
                CY_FETCH: begin
                    pc_d  = pc_incr;
                    dec_d = dec_now;
                    unique case (dec_now.kind)
                        OP_JP_ABS, OP_JP_CC: cyc_d = CY_RD_LO;
                        OP_JR, OP_JR_CC:     cyc_d = CY_RD_DISP;
                        OP_PREFIX:           cyc_d = CY_PFETCH;
                        OP_JP_PTR: begin
                            pc_d      = hl_val;
                            end_instr = 1'b1;
                        end
                        default: begin
                            end_instr = 1'b1;
                            bad_op    = 1'b1;
                        end
                    endcase
                end
                CY_PFETCH: begin
                    end_instr = 1'b1;
                    cyc_d     = CY_FETCH;
                    if (mem_rdata == OPC_JP_PTR) begin
                        pc_d = dec_q.use_iy ? iy_val : ix_val;
                    end else begin
                        pc_d   = pc_incr;
                        bad_op = 1'b1;
                    end
                end
                CY_RD_LO: begin
                    lo_d  = mem_rdata;
                    pc_d  = pc_incr;
                    cyc_d = CY_RD_HI;
                end
                CY_RD_HI: begin
                    end_instr = 1'b1;
                    cyc_d     = CY_FETCH;
                    pc_d      = (dec_q.kind == OP_JP_ABS || cond_met) ? {mem_rdata, lo_q} : pc_incr;
                end
                CY_RD_DISP: begin
                    pc_d   = pc_incr;
                    disp_d = mem_rdata;
                    if (dec_q.kind == OP_JR || cond_met) begin
                        cyc_d = CY_INTERNAL;
                    end else begin
                        end_instr = 1'b1;
                        cyc_d     = CY_FETCH;
                    end
                end
                CY_INTERNAL: begin
                    end_instr = 1'b1;
                    cyc_d     = CY_FETCH;
                    pc_d      = rel_target;
                end
                default: begin
                    cyc_d = CY_FETCH;
                end
            endcase
        end
    end

    // Register the sequencer state, program counter and latched operands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc_q  <= CY_FETCH;
            pc_q   <= 16'h0000;
            dec_q  <= '{kind: OP_BAD, cond: 3'd0, use_iy: 1'b0};
            lo_q   <= 8'h00;
            disp_q <= 8'h00;
        end else begin
            cyc_q  <= cyc_d;
            pc_q   <= pc_d;
            dec_q  <= dec_d;
            lo_q   <= lo_d;
            disp_q <= disp_d;
        end
    end

    // Publish the end-of-instruction strobe and its totals for one clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            instr_done    <= 1'b0;
            illegal_op    <= 1'b0;
            instr_tstates <= '0;
            instr_mcycles <= '0;
        end else begin
            instr_done <= end_instr;
            illegal_op <= bad_op;
            if (end_instr) begin
                instr_tstates <= tot_t + TOT_W'(1);
                instr_mcycles <= tot_m + M_W'(1);
            end
        end
    end

endmodule

// File: rtl/branch_seq_chk.sv
// branch_seq_chk
// Assertion checker for branch_seq, attached by bind. It observes only the
// top-level ports and checks strobe relations and the cost of each
// finished instruction.
module branch_seq_chk #(
    parameter int TOT_W = 5,
    parameter int M_W   = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mem_rd,
    input logic             m1_cycle,
    input logic [15:0]      pc_q,
    input logic             instr_done,
    input logic [TOT_W-1:0] instr_tstates,
    input logic [M_W-1:0]   instr_mcycles,
    input logic             illegal_op
);

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (pc_q == 16'h0000 && m1_cycle && !instr_done && !illegal_op));

    assert_fetch_reads_R2: assert property (@(posedge clk) disable iff (!rst_n)
        m1_cycle |-> mem_rd);

    assert_legal_cost_R2: assert property (@(posedge clk) disable iff (!rst_n)
        instr_done |-> (instr_tstates == TOT_W'(4) || instr_tstates == TOT_W'(7) ||
                        instr_tstates == TOT_W'(8) || instr_tstates == TOT_W'(10) ||
                        instr_tstates == TOT_W'(12)));

    assert_abs_cost_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_done && instr_tstates == TOT_W'(10)) |-> instr_mcycles == M_W'(3));

    assert_ptr_cost_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_done && instr_tstates == TOT_W'(4)) |-> instr_mcycles == M_W'(1));

    assert_index_cost_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_done && instr_tstates == TOT_W'(8)) |-> instr_mcycles == M_W'(2));

    assert_rel_taken_cost_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_done && instr_tstates == TOT_W'(12)) |-> instr_mcycles == M_W'(3));

    assert_rel_skip_cost_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_done && instr_tstates == TOT_W'(7)) |-> instr_mcycles == M_W'(2));

    assert_illegal_with_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_op |-> instr_done);

    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        instr_done |=> !instr_done);

    assert_done_in_fetch_R10: assert property (@(posedge clk) disable iff (!rst_n)
        instr_done |-> m1_cycle);

endmodule

bind branch_seq branch_seq_chk #(.TOT_W(TOT_W), .M_W(M_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .mem_rd        (mem_rd),
    .m1_cycle      (m1_cycle),
    .pc_q          (pc_q),
    .instr_done    (instr_done),
    .instr_tstates (instr_tstates),
    .instr_mcycles (instr_mcycles),
    .illegal_op    (illegal_op)
);

// File: tb/branch_seq_tb.sv
// branch_seq_tb
// Directed bench: one task per scenario, each checking its own results
// against values derived from the requirements.
module branch_seq_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  flags_in = 4'h0;
    logic [15:0] hl_val = 16'h0000;
    logic [15:0] ix_val = 16'h0000;
    logic [15:0] iy_val = 16'h0000;
    logic [7:0]  mem_rdata;
    logic [15:0] mem_addr;
    logic        mem_rd, m1_cycle, instr_done, illegal_op;
    logic [15:0] pc_q;
    logic [4:0]  instr_tstates;
    logic [1:0]  instr_mcycles;

    logic [7:0]  mem [256];
    logic [15:0] cur_pc;
    int          total = 0;
    int          bad = 0;
    bit          finished = 1'b0;

    always #2 clk = ~clk;

    assign mem_rdata = mem[mem_addr[7:0]];

    branch_seq u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .flags_in      (flags_in),
        .hl_val        (hl_val),
        .ix_val        (ix_val),
        .iy_val        (iy_val),
        .mem_rdata     (mem_rdata),
        .mem_addr      (mem_addr),
        .mem_rd        (mem_rd),
        .m1_cycle      (m1_cycle),
        .pc_q          (pc_q),
        .instr_done    (instr_done),
        .instr_tstates (instr_tstates),
        .instr_mcycles (instr_mcycles),
        .illegal_op    (illegal_op)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    // Condition model: codes NZ Z NC C PO PE P M over flags {S,Z,PV,C}.
    function automatic bit bench_cond(input int code, input logic [3:0] f);
        case (code)
            0: return !f[2];
            1: return f[2];
            2: return !f[0];
            3: return f[0];
            4: return !f[1];
            5: return f[1];
            6: return !f[3];
            default: return f[3];
        endcase
    endfunction

    function automatic logic [3:0] flags_for(input int code, input bit want);
        for (int f = 0; f < 16; f++) begin
            if (bench_cond(code, 4'(f)) == want) return 4'(f);
        end
        return 4'h0;
    endfunction

    // Place an instruction at cur_pc, run it from its first fetch clock to
    // the done clock and check timing, strobes and the next address.
    task automatic exec(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2,
                        input int et, input int em, input int erd, input int em1,
                        input bit eill, input logic [15:0] enpc, input string req);
        int n = 0;
        int rdn = 0;
        int m1n = 0;
        mem[cur_pc[7:0]]         = b0;
        mem[cur_pc[7:0] + 8'd1]  = b1;
        mem[cur_pc[7:0] + 8'd2]  = b2;
        chk(mem_addr == cur_pc, "R2", "first fetch address", mem_addr, cur_pc);
        do begin
            n++;
            if (mem_rd) rdn++;
            if (m1_cycle) m1n++;
            @(negedge clk);
        end while (!instr_done && n < 64);
        chk(n == et, req, "clocks to done", n, et);
        chk(instr_tstates == 5'(et), req, "reported T-states", instr_tstates, et);
        chk(instr_mcycles == 2'(em), req, "reported M-cycles", instr_mcycles, em);
        chk(rdn == erd, "R2", "clocks with mem_rd", rdn, erd);
        chk(m1n == em1, "R2", "clocks with m1_cycle", m1n, em1);
        chk(illegal_op == eill, req, "illegal strobe", illegal_op, eill);
        chk(pc_q == enpc, req, "new program counter", pc_q, enpc);
        chk(mem_addr == enpc, "R10", "next fetch address", mem_addr, enpc);
        cur_pc = enpc;
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(pc_q == 16'h0000, "R1", "pc in reset", pc_q, 0);
        chk(instr_done == 1'b0, "R1", "done in reset", instr_done, 0);
        chk(mem_rd && m1_cycle, "R1", "fetch strobes in reset", {mem_rd, m1_cycle}, 3);
        rst_n = 1'b1;
        cur_pc = 16'h0000;
    endtask

    task automatic t_jp_abs;
        exec(8'hC3, 8'h34, 8'h12, 10, 3, 10, 4, 1'b0, 16'h1234, "R3");
        exec(8'hC3, 8'h00, 8'hA0, 10, 3, 10, 4, 1'b0, 16'hA000, "R3");
    endtask

    task automatic t_jp_cond;
        for (int code = 0; code < 8; code++) begin
            for (int w = 0; w < 2; w++) begin
                logic [15:0] tgt = 16'h2000 + 16'(code * 32 + w * 8);
                flags_in = flags_for(code, w[0]);
                exec(8'hC2 | 8'(code << 3), tgt[7:0], tgt[15:8], 10, 3, 10, 4, 1'b0,
                     w[0] ? tgt : cur_pc + 16'd3, "R4");
            end
        end
    endtask

    task automatic t_jp_hl;
        hl_val = 16'hBEEF;
        exec(8'hE9, 8'h00, 8'h00, 4, 1, 4, 4, 1'b0, 16'hBEEF, "R5");
        @(negedge clk);
        chk(instr_done == 1'b0, "R10", "done lasts one clock", instr_done, 0);
        // Resync: run the rest of the next instruction placed at cur_pc.
        hl_val = 16'h0150;
        mem[cur_pc[7:0]] = 8'hE9;
        while (!instr_done) @(negedge clk);
        chk(pc_q == 16'h0150, "R5", "second HL jump", pc_q, 16'h0150);
        cur_pc = 16'h0150;
    endtask

    task automatic t_jp_index;
        ix_val = 16'h4321;
        iy_val = 16'h8765;
        exec(8'hDD, 8'hE9, 8'h00, 8, 2, 8, 8, 1'b0, 16'h4321, "R6");
        exec(8'hFD, 8'hE9, 8'h00, 8, 2, 8, 8, 1'b0, 16'h8765, "R6");
    endtask

    task automatic t_jr;
        exec(8'hC3, 8'h00, 8'h30, 10, 3, 10, 4, 1'b0, 16'h3000, "R3");
        exec(8'h18, 8'h05, 8'h00, 12, 3, 7, 4, 1'b0, 16'h3007, "R7");
        exec(8'h18, 8'hF0, 8'h00, 12, 3, 7, 4, 1'b0, 16'h2FF9, "R7");
        exec(8'h18, 8'hFE, 8'h00, 12, 3, 7, 4, 1'b0, 16'h2FF9, "R7");
        exec(8'hC3, 8'hF0, 8'hFF, 10, 3, 10, 4, 1'b0, 16'hFFF0, "R3");
        exec(8'h18, 8'h7F, 8'h00, 12, 3, 7, 4, 1'b0, 16'h0071, "R7");
    endtask

    task automatic t_jr_cond;
        for (int kk = 0; kk < 4; kk++) begin
            for (int w = 0; w < 2; w++) begin
                flags_in = flags_for(kk, w[0]);
                if (w == 1)
                    exec(8'h20 | 8'(kk << 3), 8'h10, 8'h00, 12, 3, 7, 4, 1'b0, cur_pc + 16'h0012, "R8");
                else
                    exec(8'h20 | 8'(kk << 3), 8'h10, 8'h00, 7, 2, 7, 4, 1'b0, cur_pc + 16'h0002, "R8");
            end
        end
    endtask

    task automatic t_illegal;
        exec(8'h00, 8'h00, 8'h00, 4, 1, 4, 4, 1'b1, cur_pc + 16'd1, "R9");
        exec(8'h10, 8'h00, 8'h00, 4, 1, 4, 4, 1'b1, cur_pc + 16'd1, "R9");
        exec(8'hDD, 8'h00, 8'h00, 8, 2, 8, 8, 1'b1, cur_pc + 16'd2, "R9");
        exec(8'hFD, 8'hC3, 8'h00, 8, 2, 8, 8, 1'b1, cur_pc + 16'd2, "R9");
    endtask

    task automatic t_reset_mid;
        mem[cur_pc[7:0]]        = 8'hC3;
        mem[cur_pc[7:0] + 8'd1] = 8'h55;
        mem[cur_pc[7:0] + 8'd2] = 8'h66;
        repeat (5) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(pc_q == 16'h0000, "R1", "pc after mid-instruction reset", pc_q, 0);
        chk(!instr_done && !illegal_op, "R1", "strobes after reset", {instr_done, illegal_op}, 0);
        rst_n = 1'b1;
        cur_pc = 16'h0000;
        exec(8'hC3, 8'h78, 8'h56, 10, 3, 10, 4, 1'b0, 16'h5678, "R1");
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL R10 watchdog: actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        @(negedge clk);
        t_reset();
        t_jp_abs();
        t_jp_cond();
        t_jp_hl();
        t_jp_index();
        t_jr();
        t_jr_cond();
        t_illegal();
        t_reset_mid();
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule